// File: doc/BRIEF.md
# Four-Way Pairwise-Order LRU Replacement State

This block holds the replacement state of a single set in a four-way set-associative cache. Six bits are kept, one per pair of ways. Each bit tells which way of its pair was touched more recently. Together the six bits give the complete recency order of the four ways, so the way chosen for eviction is always the exact least-recently-used one.

The surrounding cache controller reports events on a small interface:
- a read hit or a write hit, carrying the way index;
- a miss, which refills the selected victim.

The controller can also:
- pulse a purge input to restore the power-on order;
- load the state directly for diagnostics;
- restrict eviction to the upper two ways (two-way mode);
- inhibit replacement so that missed data bypasses the cache.

Tag storage, data arrays, refill sequencing and bus traffic belong to the controller.

Top module: `pwlru_set`

## Requirements
- R1: A synchronous reset or a purge sets all six bits to zero. From that state, four back-to-back misses (replacement not inhibited, four-way mode) select ways 3, 2, 1, 0 in that order.
- R2: `ev_kind` is encoded as follows: 2'b00 idle, 2'b01 read hit, 2'b10 write hit, 2'b11 miss. A read or write hit to way k rewrites only the three bits that pair k with another way, and marks k as newer than each of those ways. The other three bits keep their values.
- R3: On a miss with `repl_inhibit` low, `replace_en` is high in the same cycle. On the next clock edge the way shown on `victim_way` becomes the most recently used.
- R4: In four-way mode with a consistent state, `victim_way` is the way whose most recent access (hit or refill) is the oldest of the four.
- R5: While `repl_inhibit` is high, `replace_en` stays low and a miss leaves the state unchanged.
- R6: While `two_way` is high, `victim_way` is always 2 or 3. It is chosen by the ways 2/3 bit alone: the older of those two ways is selected. Hits still update the order of all four ways.
- R7: A purge takes priority over a simultaneous diagnostic write and over a simultaneous access event.
- R8: A diagnostic write loads `diag_data` into the state on the next edge, with priority over an access event. Bit mapping (bit value 1 means the higher-numbered way is newer): bit 5 covers ways 0/1, bit 4 covers 0/2, bit 3 covers 0/3, bit 2 covers 1/2, bit 1 covers 1/3, bit 0 covers 2/3. Loading all zeros restores the order of R1.
- R9: `victim_way` is decoded combinationally from the current state. State updates take effect at the clock edge that carries the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| purge | input | 1 | Clear the order state to its initial value |
| ev_kind | input | 2 | Access event: idle, read hit, write hit, miss |
| ev_way | input | 2 | Way index of a hit |
| two_way | input | 1 | Restrict victims to ways 2 and 3 |
| repl_inhibit | input | 1 | Suppress replacement on a miss |
| diag_we | input | 1 | Load the state from `diag_data` |
| diag_data | input | 6 | State value for a diagnostic write |
| victim_way | output | 2 | Way that a miss would replace |
| replace_en | output | 1 | High when the current miss performs a refill |

## Verification
The bound checker watches the following on every cycle:
- the purge clears the state;
- an inhibited miss neither raises `replace_en` nor moves the state;
- two-way mode never names way 0 or 1;
- after a hit, the accessed way is newer in all three of its pairs and the three bits that do not involve it are unchanged.

The bench's scenarios cover the rest, using an independent model that tracks the full access order. These are:
- that the victim is the true least-recently-used way over long mixed sequences;
- the 3, 2, 1, 0 order after a purge;
- the priority order among purge, diagnostic write and access;
- that the loaded pattern governs the victim.

// File: rtl/lru_pkg.sv
`timescale 1ns/1ps
package lru_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = $clog2(NUM_WAYS);
    localparam int PAIRS    = NUM_WAYS * (NUM_WAYS - 1) / 2;

    typedef logic [WAY_W-1:0] way_t;
    typedef logic [PAIRS-1:0] order_t;

    typedef enum logic [1:0] {
        EV_IDLE   = 2'b00,
        EV_RD_HIT = 2'b01,
        EV_WR_HIT = 2'b10,
        EV_MISS   = 2'b11
    } ev_kind_e;

    // Bit index of pair (lo, hi), lo < hi; pairs are numbered
    // from the top bit downward in lexical order.
    function automatic int pair_bit(input int lo, input int hi);
        int p;
        p = 0;
        for (int a = 0; a < lo; a++) p += NUM_WAYS - 1 - a;
        p += hi - lo - 1;
        return PAIRS - 1 - p;
    endfunction

    // A bit value of 1 means the higher-numbered way is the newer one.
    function automatic order_t touch(input order_t s, input way_t k);
        order_t r;
        r = s;
        for (int i = 0; i < NUM_WAYS; i++) begin
            for (int j = i + 1; j < NUM_WAYS; j++) begin
                if (i == int'(k)) r[pair_bit(i, j)] = 1'b0;
                if (j == int'(k)) r[pair_bit(i, j)] = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic is_oldest(input order_t s, input int w);
        logic ok;
        ok = 1'b1;
        for (int o = 0; o < NUM_WAYS; o++) begin
            if (o > w && !s[pair_bit(w, o)]) ok = 1'b0;
            if (o < w &&  s[pair_bit(o, w)]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/lru_victim_sel.sv
`timescale 1ns/1ps
module lru_victim_sel
    import lru_pkg::*;
(
    input  order_t state,
    input  logic   two_way,
    output way_t   victim
);
    localparam int HI_A = NUM_WAYS - 2;
    localparam int HI_B = NUM_WAYS - 1;

    logic [NUM_WAYS-1:0] oldest;

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_age
            assign oldest[w] = is_oldest(state, w);
        end
    endgenerate

    way_t full_pick;

    always_comb begin
        full_pick = way_t'(NUM_WAYS - 1);
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (oldest[w]) full_pick = way_t'(w);
        end
    end

    always_comb begin
        if (two_way)
            victim = state[pair_bit(HI_A, HI_B)] ? way_t'(HI_A) : way_t'(HI_B);
        else
            victim = full_pick;
    end

endmodule

// File: rtl/lru_next_state.sv
`timescale 1ns/1ps
module lru_next_state
    import lru_pkg::*;
(
    input  order_t     state,
    input  logic       purge,
    input  logic       diag_we,
    input  order_t     diag_data,
    input  logic [1:0] ev_kind,
    input  way_t       ev_way,
    input  way_t       victim,
    input  logic       repl_inhibit,
    output order_t     nxt,
    output logic       replace_en
);
    ev_kind_e kind;
    assign kind = ev_kind_e'(ev_kind);

    assign replace_en = (kind == EV_MISS) && !repl_inhibit;

    always_comb begin
        nxt = state;
        if (purge) begin
            nxt = '0;
        end else if (diag_we) begin
            nxt = diag_data;
        end else begin
            case (kind)
                EV_RD_HIT, EV_WR_HIT: nxt = touch(state, ev_way);
                EV_MISS:              if (replace_en) nxt = touch(state, victim);
                default:              nxt = state;
            endcase
        end
    end

endmodule

// File: rtl/pwlru_set.sv
`timescale 1ns/1ps
module pwlru_set
    import lru_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             purge,
    input  logic [1:0]       ev_kind,
    input  logic [WAY_W-1:0] ev_way,
    input  logic             two_way,
    input  logic             repl_inhibit,
    input  logic             diag_we,
    input  logic [PAIRS-1:0] diag_data,
    output logic [WAY_W-1:0] victim_way,
    output logic             replace_en
);
    order_t state_q;
    order_t state_d;

    lru_victim_sel u_sel (
        .state   (state_q),
        .two_way (two_way),
        .victim  (victim_way)
    );

    lru_next_state u_nxt (
        .state        (state_q),
        .purge        (purge),
        .diag_we      (diag_we),
        .diag_data    (diag_data),
        .ev_kind      (ev_kind),
        .ev_way       (ev_way),
        .victim       (victim_way),
        .repl_inhibit (repl_inhibit),
        .nxt          (state_d),
        .replace_en   (replace_en)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/pwlru_set_chk.sv
`timescale 1ns/1ps
module pwlru_set_chk
    import lru_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             purge,
    input logic [1:0]       ev_kind,
    input logic [WAY_W-1:0] ev_way,
    input logic             two_way,
    input logic             repl_inhibit,
    input logic             diag_we,
    input logic [WAY_W-1:0] victim_way,
    input logic             replace_en,
    input logic [PAIRS-1:0] state
);
    function automatic logic newest(input order_t s, input way_t k);
        logic ok;
        ok = 1'b1;
        for (int o = 0; o < NUM_WAYS; o++) begin
            if (o > int'(k) &&  s[pair_bit(int'(k), o)]) ok = 1'b0;
            if (o < int'(k) && !s[pair_bit(o, int'(k))]) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic order_t pair_mask(input way_t k);
        order_t m;
        m = '0;
        for (int o = 0; o < NUM_WAYS; o++) begin
            if (o > int'(k)) m[pair_bit(int'(k), o)] = 1'b1;
            if (o < int'(k)) m[pair_bit(o, int'(k))] = 1'b1;
        end
        return m;
    endfunction

    logic quiet_hit;
    assign quiet_hit = !purge && !diag_we &&
                       (ev_kind == EV_RD_HIT || ev_kind == EV_WR_HIT);

    AST_PURGE_ZERO: assert property (@(posedge clk) disable iff (rst)
        purge |=> (state == '0)); // R7

    AST_INHIBIT_NO_REPL: assert property (@(posedge clk) disable iff (rst)
        repl_inhibit |-> !replace_en); // R5

    AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!purge && !diag_we && repl_inhibit && ev_kind == EV_MISS) |=> $stable(state)); // R5

    AST_MISS_REPL: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == EV_MISS && !repl_inhibit) |-> replace_en); // R3

    AST_TWO_WAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        two_way |-> (victim_way >= way_t'(NUM_WAYS - 2))); // R6

    AST_HIT_NEWEST: assert property (@(posedge clk) disable iff (rst)
        quiet_hit |=> newest(state, $past(ev_way))); // R2

    AST_HIT_OTHERS_KEEP: assert property (@(posedge clk) disable iff (rst)
        quiet_hit |=> ((state & ~pair_mask($past(ev_way))) ==
                       ($past(state) & ~pair_mask($past(ev_way))))); // R2

endmodule

bind pwlru_set pwlru_set_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .purge        (purge),
    .ev_kind      (ev_kind),
    .ev_way       (ev_way),
    .two_way      (two_way),
    .repl_inhibit (repl_inhibit),
    .diag_we      (diag_we),
    .victim_way   (victim_way),
    .replace_en   (replace_en),
    .state        (state_q)
);

// File: tb/pwlru_set_bench.sv
`timescale 1ns/1ps
module pwlru_set_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       purge = 1'b0;
    logic [1:0] ev_kind = 2'b00;
    logic [1:0] ev_way = 2'b00;
    logic       two_way = 1'b0;
    logic       repl_inhibit = 1'b0;
    logic       diag_we = 1'b0;
    logic [5:0] diag_data = 6'd0;
    logic [1:0] victim_way;
    logic       replace_en;

    always #5 clk = ~clk;

    pwlru_set u_pwlru_set (
        .clk(clk), .rst(rst), .purge(purge), .ev_kind(ev_kind), .ev_way(ev_way),
        .two_way(two_way), .repl_inhibit(repl_inhibit), .diag_we(diag_we),
        .diag_data(diag_data), .victim_way(victim_way), .replace_en(replace_en)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int ord [4];   // ord[0] is the least recently used way

    // {ev_kind, ev_way}; kinds: 0 idle, 1 read hit, 2 write hit, 3 miss
    localparam logic [3:0] VEC [16] = '{
        4'b1100, 4'b1100, 4'b1100, 4'b1100,
        4'b0101, 4'b1011, 4'b1100, 4'b0100,
        4'b0000, 4'b1010, 4'b1100, 4'b0110,
        4'b0110, 4'b1100, 4'b1000, 4'b1100
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        ord = '{3, 2, 1, 0};
    endtask

    task automatic model_touch(input int k);
        int idx;
        idx = 0;
        for (int i = 0; i < 4; i++) if (ord[i] == k) idx = i;
        for (int i = idx; i < 3; i++) ord[i] = ord[i+1];
        ord[3] = k;
    endtask

    function automatic int model_victim();
        if (two_way) begin
            for (int i = 0; i < 4; i++) if (ord[i] >= 2) return ord[i];
        end
        return ord[0];
    endfunction

    // One event: drive after falling edge, check decode, clock, update model.
    task automatic step(input logic [1:0] kind, input logic [1:0] way, input string req);
        int v;
        @(negedge clk);
        ev_kind = kind;
        ev_way  = way;
        #1;
        v = model_victim();
        check(req, int'(victim_way), v);
        check("R3", int'(replace_en), (kind == 2'b11 && !repl_inhibit) ? 1 : 0);
        @(posedge clk);
        if (kind == 2'b01 || kind == 2'b10) model_touch(int'(way));
        else if (kind == 2'b11 && !repl_inhibit) model_touch(v);
        @(negedge clk);
        ev_kind = 2'b00;
    endtask

    task automatic run_tests();
        int saved;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check("R1 reset victim", int'(victim_way), 3);
        check("R1 reset replace_en", int'(replace_en), 0);

        // Table walk: first four misses give 3,2,1,0 (R1), rest exact LRU (R4)
        for (int i = 0; i < 16; i++) begin
            step(VEC[i][3:2], VEC[i][1:0], (i < 4) ? "R1" : "R4");
        end

        // R5: inhibited miss leaves order and replace_en low
        @(negedge clk);
        repl_inhibit = 1'b1;
        saved = model_victim();
        step(2'b11, 2'b00, "R5");
        #1;
        check("R5 victim held", int'(victim_way), saved);
        @(negedge clk);
        repl_inhibit = 1'b0;

        // R7: purge beats simultaneous hit to way 3 and diag write
        @(negedge clk);
        purge = 1'b1; diag_we = 1'b1; diag_data = 6'b111111;
        ev_kind = 2'b01; ev_way = 2'd3;
        @(negedge clk);
        purge = 1'b0; diag_we = 1'b0; ev_kind = 2'b00;
        model_reset();
        #1;
        check("R7 purge priority", int'(victim_way), 3);

        // R8: diag load all ones -> way 0 oldest, shown same cycle (R9)
        @(negedge clk);
        diag_we = 1'b1; diag_data = 6'b111111;
        ev_kind = 2'b01; ev_way = 2'd0;
        @(negedge clk);
        diag_we = 1'b0; ev_kind = 2'b00;
        #1;
        check("R8 diag load", int'(victim_way), 0);
        check("R9 decode after load", int'(replace_en), 0);
        // R8: zero load restores order; hit to 3 in same cycle loses
        @(negedge clk);
        diag_we = 1'b1; diag_data = 6'b000000;
        ev_kind = 2'b01; ev_way = 2'd3;
        @(negedge clk);
        diag_we = 1'b0; ev_kind = 2'b00;
        model_reset();
        #1;
        check("R8 zero restore", int'(victim_way), 3);

        // R2: hits make the way newest without disturbing others
        step(2'b01, 2'd2, "R2");
        step(2'b10, 2'd3, "R2");
        step(2'b01, 2'd0, "R2");
        step(2'b00, 2'd0, "R2");

        // R6: two-way mode, victims only 2/3, hits on low ways still tracked
        @(negedge clk);
        two_way = 1'b1;
        step(2'b11, 2'd0, "R6");
        step(2'b11, 2'd0, "R6");
        step(2'b01, 2'd2, "R6");
        step(2'b11, 2'd0, "R6");
        step(2'b01, 2'd1, "R6");
        @(negedge clk);
        two_way = 1'b0;
        #1;
        check("R6 four-way again", int'(victim_way), model_victim());
        step(2'b11, 2'd0, "R4");
        step(2'b11, 2'd0, "R4");
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule